// File: doc/BRIEF.md
# Write-Once Flash Timing Divider

This block produces a periodic one-cycle enable, about once per microsecond, that the flash controller uses to time program and erase steps. Software sets the division ratio by writing an 8-bit control register. Its low seven bits choose how many oscillator cycles make up one timing period. The top bit is a read-only flag that shows a value has been taken.

The divide field can be written once per reset and is then locked. A write is refused while a flash command is in progress, unless the post-reset initialisation sequence is still running. A refused write leaves the register unconfigured and does not use up the single write. The timing enable stays low until a value has been taken. After that it pulses once every (divide + 1) oscillator cycles.

Top module: `fdiv_timebase`

## Requirements
- R1: After reset, `rd_data` is 0x00, `loaded` is 0 and `tick` is 0.
- R2: `rd_data[7]` always equals `loaded`, and `rd_data[6:0]` always holds the stored divide value.
- R3: A write taken at a clock edge stores `wr_data[6:0]`, and `loaded` reads 1 from that edge until the next reset.
- R4: Once `loaded` is 1, every further write leaves the divide value unchanged.
- R5: `wr_data[7]` has no effect on the register. Writing it as 1 does not set `rd_data[7]`.
- R6: A write with `cmd_busy`=1 and `init_active`=0 is refused. It neither sets `loaded` nor uses up the single write, so a later write can still be taken.
- R7: A write with `init_active`=1 is taken even when `cmd_busy`=1, provided no earlier write was taken.
- R8: `tick` stays 0 whenever `loaded` is 0.
- R9: With divide value D>0, `tick` is high in the cycles k where k mod (D+1) = D. Here k=0 is the first cycle in which `loaded` reads 1. Each pulse lasts exactly one cycle.
- R10: With divide value 0, `tick` is high in every cycle in which `loaded` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; bits 6:0 are the divide value |
| cmd_busy | input | 1 | A flash command is running |
| init_active | input | 1 | Post-reset initialisation sequence is running |
| rd_data | output | 8 | Register readback: {loaded, divide} |
| loaded | output | 1 | Divider has been configured since reset |
| tick | output | 1 | One-cycle timing enable |

## Verification
The bench uses the default 7-bit divide field. This lets it reach both ends of the ratio range in separate reset phases: a value of 0 (pulse every cycle) and 127 (one pulse per 128 cycles), with a mid value of 3 in between. Resetting between phases makes the write-once lock available again. This way the refused-while-busy case, the initialisation override and the lock after the first write are all seen from a fresh start.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  localparam int FDIV_W = 7;

  typedef enum logic [1:0] {
    WR_IDLE   = 2'd0,
    WR_TAKEN  = 2'd1,
    WR_BUSY   = 2'd2,
    WR_LOCKED = 2'd3
  } wr_outcome_e;

endpackage

// File: rtl/fdiv_wr_gate.sv
module fdiv_wr_gate
  import fdiv_pkg::*;
(
  input  logic        wr_en,
  input  logic        cmd_busy,
  input  logic        init_active,
  input  logic        locked,
  output wr_outcome_e outcome,
  output logic        wr_take
);

  logic busy_block;
  logic lock_block;

  assign lock_block = wr_en && locked;
  assign busy_block = wr_en && !locked && cmd_busy && !init_active;

  always_comb begin
    if (!wr_en)          outcome = WR_IDLE;
    else if (lock_block) outcome = WR_LOCKED;
    else if (busy_block) outcome = WR_BUSY;
    else                 outcome = WR_TAKEN;
  end

  assign wr_take = (outcome == WR_TAKEN);

endmodule

// File: rtl/fdiv_reg.sv
module fdiv_reg #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_take,
  input  logic [DIV_W-1:0] wr_div,
  output logic [DIV_W-1:0] div_q,
  output logic             locked
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      locked <= 1'b0;
    end else if (wr_take && !locked) begin
      div_q  <= wr_div;
      locked <= 1'b1;
    end
  end

  AST_DIV_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(div_q)); // R4

  AST_LOADED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R3

endmodule

// File: rtl/fdiv_counter.sv
module fdiv_counter #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  function automatic logic at_period_end(input logic [DIV_W-1:0] c,
                                         input logic [DIV_W-1:0] d);
    return c == d;
  endfunction

  function automatic logic [DIV_W-1:0] next_count(input logic [DIV_W-1:0] c,
                                                  input logic             w);
    return w ? '0 : c + 1'b1;
  endfunction

  assign wrap = at_period_end(cnt_q, div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (!en) cnt_q <= '0;
    else          cnt_q <= next_count(cnt_q, wrap);
  end

  assign tick = en && wrap;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= div)); // R9

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick); // R9

endmodule

// File: rtl/fdiv_timebase.sv
module fdiv_timebase
  import fdiv_pkg::*;
#(
  parameter int DIV_W = FDIV_W,
  localparam int REG_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             cmd_busy,
  input  logic             init_active,
  output logic [REG_W-1:0] rd_data,
  output logic             loaded,
  output logic             tick
);

  wr_outcome_e      wr_outcome;
  logic             wr_take;
  logic [DIV_W-1:0] div_q;
  logic             locked;

  fdiv_wr_gate u_gate (
    .wr_en       (wr_en),
    .cmd_busy    (cmd_busy),
    .init_active (init_active),
    .locked      (locked),
    .outcome     (wr_outcome),
    .wr_take     (wr_take)
  );

  fdiv_reg #(.DIV_W(DIV_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_take (wr_take),
    .wr_div  (wr_data[DIV_W-1:0]),
    .div_q   (div_q),
    .locked  (locked)
  );

  fdiv_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (locked),
    .div   (div_q),
    .tick  (tick)
  );

  assign loaded  = locked;
  assign rd_data = {locked, div_q};

  AST_BUSY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cmd_busy && !init_active && !loaded) |=> !loaded); // R6

  AST_INIT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && init_active && !loaded) |=> (loaded && rd_data[DIV_W-1:0] == $past(wr_data[DIV_W-1:0]))); // R7

  AST_BIT7_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[REG_W-1] && cmd_busy && !init_active && !loaded) |=> !rd_data[REG_W-1]); // R5

  AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> !tick); // R8

  AST_REFUSE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_outcome == WR_LOCKED) |=> $stable(rd_data)); // R4

endmodule

// File: tb/tb_fdiv_timebase.sv
module tb_fdiv_timebase;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cmd_busy = 1'b0;
  logic       init_active = 1'b0;
  logic [7:0] rd_data;
  logic       loaded;
  logic       tick;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] rd;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  logic       m_loaded = 1'b0;
  logic [6:0] m_div = 7'd0;
  int         k = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  fdiv_timebase dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_busy(cmd_busy), .init_active(init_active),
    .rd_data(rd_data), .loaded(loaded), .tick(tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop plus tick model
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(rd_data == e.rd, e.req, rd_data, e.rd);
      check(loaded == e.rd[7], "R2", loaded, e.rd[7]);
    end
    if (rst_n) begin
      logic et;
      if (!m_loaded) begin
        et = 1'b0;
        check(tick == et, "R8", tick, et);
      end else begin
        et = ((k % (m_div + 1)) == m_div);
        check(tick == et, (m_div == 0) ? "R10" : "R9", tick, et);
        k++;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_loaded = 1'b0;
    m_div = 7'd0;
    k = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(rd_data == 8'h00 && loaded == 1'b0 && tick == 1'b0, "R1",
          {rd_data, loaded, tick}, 0);
  endtask

  // driver: one write cycle, expectation pushed after the edge
  task automatic do_write(input logic [7:0] d, input logic busy, input logic init,
                          input string req);
    bit take;
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    cmd_busy = busy;
    init_active = init;
    take = !m_loaded && (!busy || init);
    @(posedge clk);
    if (take) begin
      m_loaded = 1'b1;
      m_div = d[6:0];
      k = 0;
    end
    sb_q.push_back('{rd: {m_loaded, m_div}, req: req});
    #1;
    wr_en = 1'b0;
    cmd_busy = 1'b0;
    init_active = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    // phase A: busy refusal, init override, lock
    do_reset();
    idle(10);                                   // R8
    do_write(8'h85, 1'b1, 1'b0, "R6 R5");       // refused, bit7 not set
    do_write(8'h83, 1'b1, 1'b1, "R7 R3");       // taken, div=3
    do_write(8'h10, 1'b0, 1'b0, "R4");          // locked
    do_write(8'h7F, 1'b1, 1'b1, "R4");          // locked even in init
    idle(40);                                   // R9 period 4

    // phase B: divide by one
    do_reset();
    do_write(8'h00, 1'b0, 1'b0, "R3");
    idle(12);                                   // R10
    do_write(8'h05, 1'b0, 1'b0, "R4");

    // phase C: maximum ratio
    do_reset();
    do_write(8'h05, 1'b1, 1'b0, "R6");
    do_write(8'h7F, 1'b0, 1'b0, "R3 R6");
    idle(300);                                  // R9 period 128

    // phase D: bit 7 of write data with a taken write
    do_reset();
    do_write(8'h89, 1'b0, 1'b0, "R5 R2");
    idle(25);

    idle(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule